// File: doc/BRIEF.md
# Dual-Core Mailbox FIFO Pair

This block lets two processor cores that share one clock pass 32-bit messages to each other. It holds two first-in first-out queues, each eight words deep. The queue filled by core 0 is drained by core 1, and the queue filled by core 1 is drained by core 0. Each core sees one register window: a write-only transmit slot that feeds its outgoing queue, a read-only receive slot that drains its incoming queue, and a status word.

The block has two bus ports. Each port carries a core-ID bit, and the block decodes every access through the view of that core. The same address therefore reaches a different queue depending on which core is asking. Reads return data in the same cycle. Pushes, pops and flag updates take effect at the next clock edge.

Each queue is controlled by a small state machine with three states. `F_EMPTY` holds no words. `F_PART` holds between one and DEPTH-1 words. `F_FULL` holds DEPTH words. Its transitions are:
- fill: `F_EMPTY` to `F_PART`, or straight to `F_FULL` when DEPTH is 1.
- top-up: `F_PART` to `F_FULL`.
- drain: `F_PART` to `F_EMPTY`.
- release: `F_FULL` to `F_PART`, or to `F_EMPTY` when DEPTH is 1.
- hold: the state stays the same.

Each core also has two sticky error bits and an interrupt line.

Top module: `mbox_pair`

## Requirements
- R1: After reset both queues are empty. Each core's status reads 0x2 (ready set, all other bits clear), and both interrupt lines are low.
- R2: Words pushed by core 0 come out of core 1's receive slot in push order, and words pushed by core 1 come out of core 0's receive slot in push order. The two directions are independent.
- R3: A queue accepts exactly DEPTH (8) words without being drained. After the eighth word the writer's ready bit (status bit 1) reads 0. A core's valid bit (status bit 0) reads 1 exactly when its incoming queue holds data.
- R4: A push into a full queue is dropped: the queue contents and count are unchanged. The push sets the writer's sticky overflow bit (status bit 2) at the next edge.
- R5: A read of an empty receive slot returns zero and leaves the queue unchanged. It sets the reader's sticky underflow bit (status bit 3) at the next edge.
- R6: Writing any value to the status address clears that core's overflow and underflow bits and leaves the other core's bits unchanged. If an error occurs in the same cycle as the clear, the set wins.
- R7: Each core's interrupt is high exactly when that core's valid, overflow or underflow bit is set.
- R8: A port's core-ID bit selects the view. With ID 0 the transmit slot feeds the 0-to-1 queue and the receive slot drains the 1-to-0 queue. With ID 1 these are swapped. Two ports active in one cycle must carry different IDs.
- R9: Accesses from both cores in the same cycle all complete. A push and a pop on the same queue holding 1 to DEPTH-1 words leave its count unchanged, and the popped word is the old head.
- R10: The address map is 0 for status, 1 for transmit (write), 2 for receive (read) and 3 unused. A read of addresses 1 or 3 returns zero. A write to addresses 2 or 3 is ignored. Reading the status word changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock of both cores |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 2 | Access strobe, one bit per port |
| bus_wr | input | 2 | 1 = write, 0 = read, one bit per port |
| bus_cid | input | 2 | Core ID of the accessing core, one bit per port |
| bus_addr | input | 2x2 | Word address per port |
| bus_wdata | input | 2x32 | Write data per port |
| bus_rdata | output | 2x32 | Same-cycle read data per port |
| irq | output | 2 | Interrupt per core, index = core ID |

## Verification
The bound checker watches every cycle for the following:
- a queue's count never exceeds its depth;
- a push into a full queue raises the writer's overflow bit and leaves the count at its depth;
- a read of an empty queue raises the reader's underflow bit and leaves the queue empty;
- a status clear with no error in the same cycle leaves both sticky bits low;
- a set sticky bit or pending data holds the interrupt high;
- a balanced push and pop keeps the count steady;
- the two ports never present the same core ID together.

Only the directed scenarios can show data ordering across the two directions, the values of the dropped and zero-returned words, the exact status encodings, and that reads of status or unused addresses leave the queues untouched.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int NCORE = 2;
    localparam int NPORT = 2;
    localparam int AW    = 2;

    typedef enum logic [AW-1:0] {
        A_STAT = 2'd0,
        A_TX   = 2'd1,
        A_RX   = 2'd2,
        A_NONE = 2'd3
    } mbx_addr_e;

    localparam int ST_VLD = 0;
    localparam int ST_RDY = 1;
    localparam int ST_WOF = 2;
    localparam int ST_ROE = 3;

    typedef enum logic [1:0] {
        F_EMPTY = 2'd0,
        F_PART  = 2'd1,
        F_FULL  = 2'd2
    } fifo_state_e;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo
    import mbx_pkg::*;
#(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic                         pop,
    input  logic [W-1:0]                 wdata,
    output logic [W-1:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0]   cnt,
    output logic                         empty,
    output logic                         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q, cnt_d;
    fifo_state_e   state_q, state_d;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        cnt_d   = cnt_q + CW'(push) - CW'(pop);
        state_d = state_q;
        unique case (state_q)
            F_EMPTY: if (push) state_d = (cnt_d == CW'(DEPTH)) ? F_FULL : F_PART;
            F_PART: begin
                if (cnt_d == '0)               state_d = F_EMPTY;
                else if (cnt_d == CW'(DEPTH))  state_d = F_FULL;
                else                           state_d = F_PART;
            end
            F_FULL:  if (pop && !push) state_d = (cnt_d == '0) ? F_EMPTY : F_PART;
            default: state_d = F_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= F_EMPTY;
            cnt_q   <= '0;
            wp_q    <= '0;
            rp_q    <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (push) wp_q <= bump(wp_q);
            if (pop)  rp_q <= bump(rp_q);
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wp_q] <= wdata;
    end

    always_comb begin
        empty = (state_q == F_EMPTY);
        full  = (state_q == F_FULL);
        cnt   = cnt_q;
        head  = mem[rp_q];
    end
endmodule

// File: rtl/mbx_port_dec.sv
module mbx_port_dec
    import mbx_pkg::*;
(
    input  logic          sel,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    output logic          tx_wr,
    output logic          rx_rd,
    output logic          st_wr
);
    always_comb begin
        tx_wr = 1'b0;
        rx_rd = 1'b0;
        st_wr = 1'b0;
        if (sel) begin
            unique case (mbx_addr_e'(addr))
                A_STAT:  st_wr = wr;
                A_TX:    tx_wr = wr;
                A_RX:    rx_rd = !wr;
                A_NONE:  ;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mbx_flags.sv
module mbx_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic set_wof,
    input  logic set_roe,
    input  logic clr,
    output logic wof,
    output logic roe
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wof <= 1'b0;
            roe <= 1'b0;
        end else begin
            if (set_wof)  wof <= 1'b1;
            else if (clr) wof <= 1'b0;
            if (set_roe)  roe <= 1'b1;
            else if (clr) roe <= 1'b0;
        end
    end
endmodule

// File: rtl/mbox_pair.sv
module mbox_pair
    import mbx_pkg::*;
#(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NPORT-1:0]          bus_sel,
    input  logic [NPORT-1:0]          bus_wr,
    input  logic [NPORT-1:0]          bus_cid,
    input  logic [NPORT-1:0][AW-1:0]  bus_addr,
    input  logic [NPORT-1:0][W-1:0]   bus_wdata,
    output logic [NPORT-1:0][W-1:0]   bus_rdata,
    output logic [NCORE-1:0]          irq
);
    localparam int CW = $clog2(DEPTH+1);

    logic [NPORT-1:0] p_tx, p_rx, p_st;
    logic [NCORE-1:0] push_req, pop_req, st_clr;
    logic [NCORE-1:0] push_ok, pop_ok, full, empty;
    logic [NCORE-1:0] vld, rdy, wof, roe;
    logic [NCORE-1:0][W-1:0]  push_data, head;
    logic [NCORE-1:0][CW-1:0] cnt;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        mbx_port_dec u_dec (
            .sel   (bus_sel[p]),
            .wr    (bus_wr[p]),
            .addr  (bus_addr[p]),
            .tx_wr (p_tx[p]),
            .rx_rd (p_rx[p]),
            .st_wr (p_st[p])
        );

        always_comb begin
            bus_rdata[p] = '0;
            if (bus_sel[p] && !bus_wr[p]) begin
                unique case (mbx_addr_e'(bus_addr[p]))
                    A_STAT: begin
                        bus_rdata[p][ST_VLD] = vld[bus_cid[p]];
                        bus_rdata[p][ST_RDY] = rdy[bus_cid[p]];
                        bus_rdata[p][ST_WOF] = wof[bus_cid[p]];
                        bus_rdata[p][ST_ROE] = roe[bus_cid[p]];
                    end
                    A_RX:    bus_rdata[p] = empty[~bus_cid[p]] ? '0 : head[~bus_cid[p]];
                    A_TX:    ;
                    A_NONE:  ;
                    default: ;
                endcase
            end
        end
    end

    // Queue d is written by core d and drained by core 1-d.
    always_comb begin
        push_req  = '0;
        pop_req   = '0;
        st_clr    = '0;
        push_data = '0;
        for (int d = 0; d < NCORE; d++) begin
            for (int p = 0; p < NPORT; p++) begin
                if (p_tx[p] && bus_cid[p] == 1'(d)) begin
                    push_req[d]  = 1'b1;
                    push_data[d] = bus_wdata[p];
                end
                if (p_rx[p] && bus_cid[p] == 1'(NCORE-1-d)) pop_req[d] = 1'b1;
                if (p_st[p] && bus_cid[p] == 1'(d))         st_clr[d]  = 1'b1;
            end
        end
    end

    for (genvar d = 0; d < NCORE; d++) begin : g_q
        assign push_ok[d] = push_req[d] && !full[d];
        assign pop_ok[d]  = pop_req[d] && !empty[d];

        mbx_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (push_ok[d]),
            .pop   (pop_ok[d]),
            .wdata (push_data[d]),
            .head  (head[d]),
            .cnt   (cnt[d]),
            .empty (empty[d]),
            .full  (full[d])
        );
    end

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        localparam int RQ = NCORE - 1 - c;

        assign vld[c] = !empty[RQ];
        assign rdy[c] = !full[c];

        mbx_flags u_flags (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_wof (push_req[c] && full[c]),
            .set_roe (pop_req[RQ] && empty[RQ]),
            .clr     (st_clr[c]),
            .wof     (wof[c]),
            .roe     (roe[c])
        );

        assign irq[c] = vld[c] | wof[c] | roe[c];
    end
endmodule

// File: rtl/mbox_pair_chk.sv
module mbox_pair_chk #(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [1:0]           bus_sel,
    input logic [1:0]           bus_cid,
    input logic [1:0]           push_req,
    input logic [1:0]           pop_req,
    input logic [1:0]           push_ok,
    input logic [1:0]           pop_ok,
    input logic [1:0]           full,
    input logic [1:0]           empty,
    input logic [1:0]           st_clr,
    input logic [1:0]           wof,
    input logic [1:0]           roe,
    input logic [1:0]           irq,
    input logic [1:0][CW-1:0]   cnt
);
    p_distinct_ids_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel[0] && bus_sel[1]) |-> (bus_cid[0] != bus_cid[1]));

    for (genvar d = 0; d < 2; d++) begin : g_chk
        localparam int OTHER = 1 - d;

        p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
            cnt[d] <= CW'(DEPTH));

        p_overflow_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (push_req[d] && full[d]) |=> wof[d]);

        p_overflow_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (push_req[d] && full[d] && !pop_req[d]) |=> (cnt[d] == CW'(DEPTH)));

        p_underflow_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (pop_req[d] && empty[d]) |=> roe[OTHER]);

        p_underflow_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (pop_req[d] && empty[d] && !push_req[d]) |=> empty[d]);

        p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (st_clr[d] && !(push_req[d] && full[d]) && !(pop_req[OTHER] && empty[OTHER]))
            |=> (!wof[d] && !roe[d]));

        p_irq_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (wof[d] || roe[d]) |-> irq[d]);

        p_irq_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !empty[OTHER] |-> irq[d]);

        p_balance_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (push_ok[d] && pop_ok[d]) |=> $stable(cnt[d]));
    end
endmodule

bind mbox_pair mbox_pair_chk #(.DEPTH(DEPTH), .CW($clog2(DEPTH+1))) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_cid  (bus_cid),
    .push_req (push_req),
    .pop_req  (pop_req),
    .push_ok  (push_ok),
    .pop_ok   (pop_ok),
    .full     (full),
    .empty    (empty),
    .st_clr   (st_clr),
    .wof      (wof),
    .roe      (roe),
    .irq      (irq),
    .cnt      (cnt)
);

// File: tb/sim_mbox_pair.sv
module sim_mbox_pair;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 32;
    localparam int DEPTH      = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       bus_sel = '0;
    logic [1:0]       bus_wr = '0;
    logic [1:0]       bus_cid = '0;
    logic [1:0][1:0]  bus_addr = '0;
    logic [1:0][W-1:0] bus_wdata = '0;
    logic [1:0][W-1:0] bus_rdata;
    logic [1:0]       irq;

    int checks = 0;
    int errors = 0;

    mbox_pair #(.W(W), .DEPTH(DEPTH)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_cid   (bus_cid),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic idle();
        bus_sel = '0; bus_wr = '0; bus_cid = '0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic op1(input int p, input logic cid, input logic wr, input logic [1:0] a,
                       input logic [W-1:0] wd, output logic [W-1:0] rd);
        @(negedge clk);
        bus_sel[p] = 1'b1; bus_wr[p] = wr; bus_cid[p] = cid;
        bus_addr[p] = a; bus_wdata[p] = wd;
        #1 rd = bus_rdata[p];
        @(posedge clk);
        #1 idle();
    endtask

    task automatic op2(input logic wr0, input logic [1:0] a0, input logic [W-1:0] wd0,
                       input logic wr1, input logic [1:0] a1, input logic [W-1:0] wd1,
                       output logic [W-1:0] rd0, output logic [W-1:0] rd1);
        @(negedge clk);
        bus_sel = 2'b11; bus_wr = {wr1, wr0}; bus_cid = 2'b10;
        bus_addr[0] = a0; bus_addr[1] = a1;
        bus_wdata[0] = wd0; bus_wdata[1] = wd1;
        #1 rd0 = bus_rdata[0]; rd1 = bus_rdata[1];
        @(posedge clk);
        #1 idle();
    endtask

    task automatic wr_tx(input int c, input logic [W-1:0] d);
        logic [W-1:0] x;
        op1(c, 1'(c), 1'b1, 2'd1, d, x);
    endtask

    task automatic rd_rx(input int c, output logic [W-1:0] d);
        op1(c, 1'(c), 1'b0, 2'd2, '0, d);
    endtask

    task automatic rd_st(input int c, output logic [W-1:0] d);
        op1(c, 1'(c), 1'b0, 2'd0, '0, d);
    endtask

    task automatic clr_st(input int c);
        logic [W-1:0] x;
        op1(c, 1'(c), 1'b1, 2'd0, 32'hFFFF_FFFF, x);
    endtask

    task automatic t_reset();
        logic [W-1:0] s;
        rd_st(0, s); chk("R1 core0 status", s, 32'h2);
        rd_st(1, s); chk("R1 core1 status", s, 32'h2);
        chk("R1 irq", {30'd0, irq}, 32'h0);
    endtask

    task automatic t_cross();
        logic [W-1:0] s;
        wr_tx(0, 32'hA000_0001); wr_tx(0, 32'hA000_0002); wr_tx(0, 32'hA000_0003);
        rd_st(1, s); chk("R3 core1 valid", s, 32'h3);
        chk("R7 irq with data", {30'd0, irq}, 32'h2);
        rd_st(0, s); chk("R2 core0 own rx empty", s, 32'h2);
        rd_rx(1, s); chk("R2 order 1", s, 32'hA000_0001);
        rd_rx(1, s); chk("R2 order 2", s, 32'hA000_0002);
        rd_rx(1, s); chk("R2 order 3", s, 32'hA000_0003);
        rd_st(1, s); chk("R2 core1 drained", s, 32'h2);
        wr_tx(1, 32'hB000_00B1);
        rd_rx(0, s); chk("R2 reverse path", s, 32'hB000_00B1);
    endtask

    task automatic t_cid();
        logic [W-1:0] s;
        op1(1, 1'b0, 1'b1, 2'd1, 32'hC1D0_0000, s);
        op1(0, 1'b1, 1'b0, 2'd2, '0, s);
        chk("R8 view follows core id", s, 32'hC1D0_0000);
    endtask

    task automatic t_full();
        logic [W-1:0] s;
        for (int i = 0; i < DEPTH; i++) wr_tx(0, 32'd100 + 32'(i));
        rd_st(0, s); chk("R3 ready low when full", s, 32'h0);
        wr_tx(0, 32'd999);
        rd_st(0, s); chk("R4 overflow flag", s, 32'h4);
        chk("R7 irq on overflow", {30'd0, irq}, 32'h3);
        for (int i = 0; i < DEPTH; i++) begin
            rd_rx(1, s); chk("R4 kept words in order", s, 32'd100 + 32'(i));
        end
        rd_st(1, s); chk("R4 dropped word absent", s, 32'h2);
        rd_rx(1, s); chk("R5 empty read returns zero", s, 32'h0);
        rd_st(1, s); chk("R5 underflow flag", s, 32'ha);
        chk("R7 irq on underflow", {30'd0, irq}, 32'h3);
    endtask

    task automatic t_clear();
        logic [W-1:0] s;
        clr_st(1);
        rd_st(1, s); chk("R6 core1 cleared", s, 32'h2);
        rd_st(0, s); chk("R6 core0 untouched", s, 32'h6);
        clr_st(0);
        rd_st(0, s); chk("R6 core0 cleared", s, 32'h2);
        chk("R7 irq idle", {30'd0, irq}, 32'h0);
    endtask

    task automatic t_dual();
        logic [W-1:0] s, r0, r1;
        wr_tx(0, 32'hE0); wr_tx(0, 32'hE1);
        op2(1'b1, 2'd1, 32'hE2, 1'b0, 2'd2, '0, r0, r1);
        chk("R9 pop during push", r1, 32'hE0);
        rd_rx(1, s); chk("R9 next word", s, 32'hE1);
        rd_rx(1, s); chk("R9 pushed word", s, 32'hE2);
        rd_st(1, s); chk("R9 count balanced", s, 32'h2);
        op2(1'b1, 2'd1, 32'hF0, 1'b1, 2'd1, 32'hF1, r0, r1);
        rd_rx(0, s); chk("R9 core1 push done", s, 32'hF1);
        rd_rx(1, s); chk("R9 core0 push done", s, 32'hF0);
    endtask

    task automatic t_map();
        logic [W-1:0] s;
        wr_tx(1, 32'h6060_6060);
        op1(1, 1'b1, 1'b0, 2'd1, '0, s); chk("R10 tx read zero", s, 32'h0);
        op1(1, 1'b1, 1'b0, 2'd3, '0, s); chk("R10 unused read zero", s, 32'h0);
        op1(0, 1'b0, 1'b1, 2'd2, 32'h1234_5678, s);
        op1(0, 1'b0, 1'b1, 2'd3, 32'h1234_5678, s);
        rd_st(0, s); chk("R10 no side effect", s, 32'h3);
        rd_st(0, s); chk("R10 status read repeat", s, 32'h3);
        rd_rx(0, s); chk("R10 word intact", s, 32'h6060_6060);
        rd_st(0, s); chk("R10 drained", s, 32'h2);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_cross();
        t_cid();
        t_full();
        t_clear();
        t_dual();
        t_map();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule